// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (clock master, three framings)

This block drives a three-wire stereo audio link as the clock master. From one master clock it derives the bit clock and the channel-select clock. It then shifts out two's-complement left and right samples, most significant bit first, on a single data line. A two-bit format input picks the bit placement inside each channel slot: standard I2S (one-bit delay), left-justified or right-justified. A width input sets the sample length in bits, from 16 to 32, inside a fixed 32-bit channel slot. Slot positions that carry no sample bit are sent as zero.

The sample source sees a single-cycle request strobe shortly before each frame begins. A pair offered with valid high during that strobe is taken for the coming frame. If valid is low, the previous pair is sent again. The format and width are captured at the same instant, so changing them part-way through a frame has no effect until the next frame. The bit clock runs at a quarter of the master clock, and a frame lasts 64 bit periods. With a master clock of 256 times the sample rate, the channel-select clock runs at the sample rate.

Top module: `i2s_tx_master`

## Requirements
- R1: `bclk_o` has a period of 4 `clk` cycles and is high for the last two of them. `lrck_o` has a period of 64 bit periods. It is low (left channel) for the first 32 bit slots of a frame and high (right channel) for the last 32.
- R2: `lrck_o` and `sdata_o` change only in the `clk` cycle in which `bclk_o` falls. Each bit slot therefore starts on a falling bit-clock edge.
- R3: With `fmt_i` = 0 or 3 (standard), the data lags the channel clock by one slot. The left MSB is in slot 1 and the right MSB is in slot 33. Slot 0 carries the LSB of the previous right word only when the previous frame was also standard at width 32; otherwise slot 0 is zero.
- R4: With `fmt_i` = 1 (left-justified), the left MSB is in slot 0 and the right MSB is in slot 32.
- R5: With `fmt_i` = 2 (right-justified), the LSB of each word is in the last slot of its channel (slots 31 and 63). For width W, the MSB is in channel position 32-W.
- R6: Each word is sent MSB first. Only the lowest W bits of each input word are used, and every channel position holding no sample bit is zero.
- R7: The width taken from `width_i` is clamped to a minimum of 16 and a maximum of 32.
- R8: `req_o` is high for exactly one `clk` cycle, the cycle just before the first left slot of a frame begins. If `valid_i` is high in that cycle, `left_i` and `right_i` are taken for the frame. Otherwise the previous pair is repeated. Data and valid outside that cycle are ignored.
- R9: `fmt_i` and `width_i` are sampled only in the `req_o` cycle. Changes at any other time do not alter the frame in progress.
- R10: While `rst` is high, and after it until the first frame starts, `bclk_o`, `lrck_o`, `sdata_o` and `req_o` are 0 (except `bclk_o` as per R1). The first `req_o` comes 3 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Framing select: 0/3 standard, 1 left-justified, 2 right-justified |
| width_i | input | 6 | Sample width in bits, clamped to 16..32 |
| valid_i | input | 1 | Sample pair offered |
| left_i | input | 32 | Left sample, two's complement, right-aligned |
| right_i | input | 32 | Right sample, two's complement, right-aligned |
| req_o | output | 1 | One-cycle request / accept strobe before each frame |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Channel select, low = left |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions assume a master clock divider of at least 4 and a reset held for at least one clock. They place no constraint on the sample inputs, since those are only consulted in the strobe cycle. The stimulus changes every input on the falling master-clock edge. Valid stays high with junk data and a different format and width after each strobe, so any sampling outside the strobe shows up as a data mismatch. Frames with valid low, out-of-range widths and changes of format between frames are included, so the repeat, clamp and slot-0 carry-over cases are exercised.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

  typedef enum logic [1:0] {
    FMT_STD  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_STD2 = 2'd3
  } fmt_e;

  function automatic logic is_std(fmt_e f);
    return (f == FMT_STD) || (f == FMT_STD2);
  endfunction

endpackage

// File: rtl/i2stx_clkdiv.sv
module i2stx_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic bclk_o,
  output logic bit_tick_o,
  output logic pre_tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] PRE  = CW'(DIV - 2);
  localparam logic [CW-1:0] HI   = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : CW'(cnt_q + 1'b1);
      if (cnt_q == HI)
        bclk_o <= 1'b1;
      else if (cnt_q == LAST)
        bclk_o <= 1'b0;
    end
  end

  assign bit_tick_o = (cnt_q == LAST);
  assign pre_tick_o = (cnt_q == PRE);
endmodule

// File: rtl/i2stx_framer.sv
module i2stx_framer #(
  parameter int FRAME_BITS = 64,
  parameter int SW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick_i,
  input  logic          pre_tick_i,
  output logic [SW-1:0] slot_nxt_o,
  output logic          load_o,
  output logic          req_o
);
  localparam logic [SW-1:0] LAST = SW'(FRAME_BITS - 1);

  logic [SW-1:0] slot_q;

  assign slot_nxt_o = (slot_q == LAST) ? '0 : SW'(slot_q + 1'b1);
  assign load_o     = bit_tick_i && (slot_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= LAST;
      req_o  <= 1'b0;
    end else begin
      if (bit_tick_i)
        slot_q <= slot_nxt_o;
      req_o <= pre_tick_i && (slot_q == LAST);
    end
  end
endmodule

// File: rtl/i2stx_hold.sv
module i2stx_hold
  import i2stx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int SLOT_W   = 32,
  parameter int MIN_W    = 16,
  parameter int WID_W    = 6,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  fmt_e                fmt_i,
  input  logic [WID_W-1:0]    width_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output fmt_e                fmt_o,
  output logic [CNT_W-1:0]    w_o,
  output logic                tail_o
);
  logic [SAMPLE_W-1:0] left_q, right_q;
  fmt_e                fmt_q;
  logic [CNT_W-1:0]    w_q, w_clamp;
  logic                tail_q;

  always_comb begin
    if (int'(width_i) < MIN_W)
      w_clamp = CNT_W'(MIN_W);
    else if (int'(width_i) > SAMPLE_W)
      w_clamp = CNT_W'(SAMPLE_W);
    else
      w_clamp = CNT_W'(width_i);
  end

  always_comb begin
    left_o  = left_q;
    right_o = right_q;
    fmt_o   = fmt_q;
    w_o     = w_q;
    tail_o  = tail_q;
    if (load_i) begin
      fmt_o  = fmt_i;
      w_o    = w_clamp;
      tail_o = is_std(fmt_q) && (int'(w_q) == SLOT_W) && right_q[0];
      if (valid_i) begin
        left_o  = left_i;
        right_o = right_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
      fmt_q   <= FMT_STD;
      w_q     <= CNT_W'(SAMPLE_W);
      tail_q  <= 1'b0;
    end else begin
      left_q  <= left_o;
      right_q <= right_o;
      fmt_q   <= fmt_o;
      w_q     <= w_o;
      tail_q  <= tail_o;
    end
  end
endmodule

// File: rtl/i2stx_bitsel.sv
module i2stx_bitsel
  import i2stx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int SLOT_W   = 32,
  parameter int SW       = 6,
  parameter int CNT_W    = 6
) (
  input  logic [SW-1:0]       slot_i,
  input  fmt_e                fmt_i,
  input  logic [CNT_W-1:0]    w_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                tail_i,
  output logic                bit_o
);
  localparam int IW = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  always_comb begin
    int q, p, w, idx;
    logic use_tail;
    logic [SAMPLE_W-1:0] word;
    w        = int'(w_i);
    q        = int'(slot_i);
    use_tail = 1'b0;
    bit_o    = 1'b0;
    if (is_std(fmt_i)) begin
      if (q == 0) use_tail = 1'b1;
      else        q = q - 1;
    end
    if (q >= SLOT_W) begin
      p    = q - SLOT_W;
      word = right_i;
    end else begin
      p    = q;
      word = left_i;
    end
    if (fmt_i == FMT_RJ) idx = SLOT_W - 1 - p;
    else                 idx = w - 1 - p;
    if (use_tail)
      bit_o = tail_i;
    else if (idx >= 0 && idx < w)
      bit_o = word[IW'(idx)];
  end
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2stx_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 32,
  parameter int MIN_W    = 16,
  parameter int WID_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmt_i,
  input  logic [WID_W-1:0]    width_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                req_o,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic                sdata_o
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int SW         = $clog2(FRAME_BITS);
  localparam int CNT_W      = $clog2(SAMPLE_W + 1);

  logic                bit_tick, pre_tick, load;
  logic [SW-1:0]       slot_nxt;
  logic [SAMPLE_W-1:0] cur_left, cur_right;
  fmt_e                cur_fmt;
  logic [CNT_W-1:0]    cur_w;
  logic                cur_tail, next_bit;

  i2stx_clkdiv #(.DIV(DIV)) clkdiv_i (
    .clk(clk), .rst(rst), .bclk_o(bclk_o),
    .bit_tick_o(bit_tick), .pre_tick_o(pre_tick)
  );

  i2stx_framer #(.FRAME_BITS(FRAME_BITS), .SW(SW)) framer_i (
    .clk(clk), .rst(rst), .bit_tick_i(bit_tick), .pre_tick_i(pre_tick),
    .slot_nxt_o(slot_nxt), .load_o(load), .req_o(req_o)
  );

  i2stx_hold #(
    .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .MIN_W(MIN_W),
    .WID_W(WID_W), .CNT_W(CNT_W)
  ) hold_i (
    .clk(clk), .rst(rst), .load_i(load), .valid_i(valid_i),
    .left_i(left_i), .right_i(right_i), .fmt_i(fmt_e'(fmt_i)),
    .width_i(width_i), .left_o(cur_left), .right_o(cur_right),
    .fmt_o(cur_fmt), .w_o(cur_w), .tail_o(cur_tail)
  );

  i2stx_bitsel #(
    .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SW(SW), .CNT_W(CNT_W)
  ) bitsel_i (
    .slot_i(slot_nxt), .fmt_i(cur_fmt), .w_i(cur_w),
    .left_i(cur_left), .right_i(cur_right), .tail_i(cur_tail),
    .bit_o(next_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_o  <= 1'b0;
      sdata_o <= 1'b0;
    end else if (bit_tick) begin
      lrck_o  <= (int'(slot_nxt) >= SLOT_W);
      sdata_o <= next_bit;
    end
  end
endmodule

// File: rtl/i2stx_checker.sv
module i2stx_checker (
  input logic clk,
  input logic rst,
  input logic req_o,
  input logic bclk_o,
  input logic lrck_o,
  input logic sdata_o
);
  a_r2_lrck_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck_o) |-> $fell(bclk_o));

  a_r2_sdata_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_o) |-> $fell(bclk_o));

  a_r8_req_single: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);

  a_r8_req_before_left: assert property (@(posedge clk) disable iff (rst)
    req_o |=> ($fell(bclk_o) && !lrck_o));

  a_r1_bclk_high_two: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk_o) |=> bclk_o);

  a_r1_lrck_fall_at_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(lrck_o) |-> $past(req_o));

  a_r10_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> (!bclk_o && !lrck_o && !sdata_o && !req_o));
endmodule

bind i2s_tx_master i2stx_checker chk_i (
  .clk(clk), .rst(rst), .req_o(req_o),
  .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
);

// File: tb/i2s_tx_master_tb.sv
module i2s_tx_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_i = 2'd0;
  logic [5:0]  width_i = 6'd32;
  logic        valid_i = 1'b0;
  logic [31:0] left_i = '0, right_i = '0;
  logic        req_o, bclk_o, lrck_o, sdata_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit started = 1'b0;
  string drv_tag = "R3";

  i2s_tx_master dut_i (
    .clk(clk), .rst(rst), .fmt_i(fmt_i), .width_i(width_i),
    .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
    .req_o(req_o), .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
  );

  always #5 clk = ~clk;

  // reference model state
  int k = 0;
  logic [31:0] cl = '0, cr = '0, pr = '0;
  int cf = 0, cw = 32, pf = 0, pw = 32;
  string ctag = "R10";

  function automatic int clampw(int w);
    if (w < 16) return 16;
    if (w > 32) return 32;
    return w;
  endfunction

  function automatic logic ref_bit(int s);
    bit std;
    int q, p;
    logic [31:0] word;
    std = (cf == 0) || (cf == 3);
    if (std && s == 0)
      return ((pf == 0 || pf == 3) && pw == 32) ? pr[0] : 1'b0;
    q = std ? s - 1 : s;
    word = (q >= 32) ? cr : cl;
    p = q % 32;
    if (cf == 2) return (p >= 32 - cw) ? word[31 - p] : 1'b0;
    return (p < cw) ? word[cw - 1 - p] : 1'b0;
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      k = 0; cl = '0; cr = '0; pr = '0;
      cf = 0; cw = 32; pf = 0; pw = 32; ctag = "R10";
    end else begin
      if (k % 4 == 3 && (k / 4) % 64 == 0) begin
        pr = cr; pf = cf; pw = cw;
        cf = int'(fmt_i);
        cw = clampw(int'(width_i));
        if (valid_i) begin cl = left_i; cr = right_i; end
        ctag = drv_tag;
      end
      k++;
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at k=%0d: actual=%b expected=%b", tag, what, k, act, exp);
    end
  endtask

  logic pb = 1'b0, pl = 1'b0, psd = 1'b0;

  always @(negedge clk) begin
    if (started) begin
      int bits, s;
      logic eb, er, el, ed;
      string dtag;
      eb = (k % 4) >= 2;
      er = (k % 4 == 3) && ((k / 4) % 64 == 0);
      bits = k / 4;
      if (bits == 0) begin
        el = 1'b0; ed = 1'b0; dtag = "R10";
      end else begin
        s = (bits - 1) % 64;
        el = (s >= 32);
        ed = ref_bit(s);
        dtag = ctag;
      end
      check(bits == 0 ? "R10" : "R1", "bclk", bclk_o, eb);
      check(bits == 0 ? "R10" : "R1", "lrck", lrck_o, el);
      check("R8", "req", req_o, er);
      check(dtag, "sdata", sdata_o, ed);
      if (!rst && ((lrck_o !== pl) || (sdata_o !== psd))) begin
        // R2: transitions only where bclk falls
        check("R2", "change_on_bclk_fall", pb && !bclk_o, 1'b1);
      end
      pb = bclk_o; pl = lrck_o; psd = sdata_o;
    end
  end

  task automatic send(int f, int w, bit v, logic [31:0] l, logic [31:0] r, string tag);
    do @(negedge clk); while (req_o !== 1'b1);
    fmt_i = 2'(f); width_i = 6'(w); valid_i = v; left_i = l; right_i = r;
    drv_tag = tag;
    @(negedge clk);
    // junk outside the strobe: must be ignored (R8, R9)
    fmt_i = 2'((f + 1) % 4); width_i = 6'(w ^ 5); valid_i = 1'b1;
    left_i = ~l; right_i = l ^ r;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    send(0, 32, 1, 32'hA5C3_1E79, 32'h3C0F_5AA7, "R3");
    send(0, 32, 1, 32'h8001_7FFE, 32'h1234_5679, "R3");
    send(0, 16, 1, 32'hFFFF_9C41, 32'h0000_6E2D, "R6");
    send(1, 24, 1, 32'h00B3_57E1, 32'h00F0_0F11, "R4");
    send(1, 16, 1, 32'h0000_D00D, 32'h0000_2BAD, "R4");
    send(2, 16, 1, 32'h5555_C3A9, 32'hAAAA_1F83, "R5");
    send(2, 32, 1, 32'hDEAD_BEEF, 32'h0BAD_F00D, "R5");
    send(2, 20, 0, 32'h1111_1111, 32'h2222_2222, "R8");
    send(3, 8, 1, 32'h0000_9A5B, 32'h0000_C001, "R7");
    send(1, 40, 1, 32'h7654_3210, 32'hFEDC_BA99, "R7");
    send(0, 32, 1, 32'hC0DE_CAFE, 32'h0F1E_2D3C, "R9");
    send(0, 32, 0, 32'h0, 32'h0, "R3");
    send(2, 24, 1, 32'h00AB_CDEF, 32'h0012_3457, "R9");
    repeat (300) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule